// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked shift mode of a small controller's serial port. It drives a bit clock on one output and moves a byte, least-significant bit first, over a single data line. When transmitting, the block drives that line. When receiving, it samples the line on each rising edge of the bit clock. Every bit occupies a fixed window of twelve core clocks, and the bit clock idles high between transfers.

Software starts a transmission with a one-cycle load strobe carrying the byte. It starts a reception by raising a receive-enable level while the port is idle. When the eighth bit completes, a sticky done flag is raised for the direction used. The flag stays set until its clear input is pulsed. A pending receive-done flag keeps a new reception from starting. The data pin is bidirectional at chip level: the block provides an output value, an output enable and an input value.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk_out=1, sd_oe=0, sd_out=1, tx_done=0, rx_done=0 and rx_byte=0.
- R2: A transfer lasts 8 windows of 12 clocks. Phase 0 is the first clock after the start edge. Within each window, sclk_out is 0 in phases 4 to 9 and 1 in phases 0 to 3, 10 and 11. This gives a 12-clock period with the rising edge at phase 10. sclk_out is 1 while idle.
- R3: A tx_load pulse seen while idle starts a transmission. In window b, sd_out holds tx_byte bit b (bit 0 first) for all 12 clocks, with sd_oe=1. Data is therefore stable 10 clocks before and 2 clocks after each rising edge.
- R4: In a reception, sd_in is captured on the clock edge at which sclk_out rises, that is, the edge that ends phase 9. Window b fills rx_byte bit b. A change on sd_in one clock after that edge has no effect.
- R5: On the edge that ends the 96th clock of a transfer, the port goes idle and tx_done (transmit) or rx_done (receive) becomes 1. On that same edge, rx_byte takes the received byte.
- R6: A done flag stays 1 until its own clear input (tx_done_clr or rx_done_clr) is high on a clock edge.
- R7: While rx_done=1, rx_enable starts no transfer: sclk_out stays 1.
- R8: A tx_load during a transfer is ignored. The bits on sd_out continue from the original byte.
- R9: If tx_load and rx_enable are both high on the same idle edge, a transmission starts (sd_oe=1) and no receive flag is set.
- R10: Outside a transmission, sd_oe=0 and sd_out=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load | input | 1 | Strobe that writes the transmit byte and starts a transmission |
| tx_byte | input | DATA_BITS | Byte to transmit |
| rx_enable | input | 1 | Level that starts a reception while idle |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| sd_in | input | 1 | Data pin input value |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| sclk_out | output | 1 | Shift clock |
| rx_byte | output | DATA_BITS | Last received byte |
| tx_done | output | 1 | Transmit complete, sticky |
| rx_done | output | 1 | Receive complete, sticky |

## Verification
Transmissions are tried with 0x00, 0xFF, 0x01 and 0x80, which separate the bit order from stuck data. Random bytes follow, and each one is compared against the expected serial waveform clock by clock. Receptions drive each bit at phase 0 and then replace it with random noise at phase 10, one clock after the rising edge. Only a capture on exactly the rising edge yields the sent byte, and these runs also use alternating and random patterns. Directed cases cover:
- a load strobe in the middle of a transfer;
- simultaneous load and receive-enable;
- receive-enable held while a receive flag is pending.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_BITS  = 8,
  parameter int BIT_CLKS   = 12,
  parameter int SETUP_CLKS = 10,
  parameter int LOW_CLKS   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_load,
  input  logic [DATA_BITS-1:0] tx_byte,
  input  logic                 rx_enable,
  input  logic                 tx_done_clr,
  input  logic                 rx_done_clr,
  input  logic                 sd_in,
  output logic                 sd_out,
  output logic                 sd_oe,
  output logic                 sclk_out,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 tx_done,
  output logic                 rx_done
);
  localparam int PW = $clog2(BIT_CLKS);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [PW-1:0] PH_LAST   = PW'(BIT_CLKS - 1);
  localparam logic [PW-1:0] PH_SAMPLE = PW'(SETUP_CLKS - 1);
  localparam logic [PW-1:0] PH_RISE   = PW'(SETUP_CLKS);
  localparam logic [PW-1:0] PH_LOW    = PW'(SETUP_CLKS - LOW_CLKS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  logic                 busy, is_tx;
  logic [PW-1:0]        phase;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;

  wire last_phase = (phase == PH_LAST);
  wire last_bit   = (bitn == BIT_LAST);

  assign sd_oe    = busy & is_tx;
  assign sd_out   = sd_oe ? shreg[0] : 1'b1;
  assign sclk_out = ~(busy && phase >= PH_LOW && phase < PH_RISE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_tx   <= 1'b0;
      phase   <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rx_byte <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (tx_done_clr) tx_done <= 1'b0;
      if (rx_done_clr) rx_done <= 1'b0;
      if (!busy) begin
        if (tx_load) begin
          busy  <= 1'b1;
          is_tx <= 1'b1;
          shreg <= tx_byte;
          phase <= '0;
          bitn  <= '0;
        end else if (rx_enable && !rx_done) begin
          busy  <= 1'b1;
          is_tx <= 1'b0;
          phase <= '0;
          bitn  <= '0;
        end
      end else begin
        if (!is_tx && phase == PH_SAMPLE)
          shreg <= {sd_in, shreg[DATA_BITS-1:1]};
        if (last_phase) begin
          phase <= '0;
          if (is_tx) shreg <= shreg >> 1;
          if (last_bit) begin
            busy <= 1'b0;
            if (is_tx) tx_done <= 1'b1;
            else begin
              rx_done <= 1'b1;
              rx_byte <= shreg;
            end
          end else begin
            bitn <= bitn + BW'(1);
          end
        end else begin
          phase <= phase + PW'(1);
        end
      end
    end
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);
  a_r2_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(sclk_out)) |-> (phase == PH_RISE));
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_tx && !last_phase) |=> $stable(sd_out));
  a_r10_oe_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (busy && is_tx));
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done);
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> rx_done);
  a_r7_no_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_done && !tx_load) |=> !busy);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !busy);
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_load = 0, rx_enable = 0, tx_done_clr = 0, rx_done_clr = 0, sd_in = 0;
  logic [7:0] tx_byte = 8'h00;
  logic sd_out, sd_oe, sclk_out, tx_done, rx_done;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sync_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_enable(rx_enable), .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .sclk_out(sclk_out),
    .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic exp_sclk(int n);
    int p = n % 12;
    return !(p >= 4 && p <= 9);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); tx_done_clr = 1; rx_done_clr = 1;
    @(negedge clk); tx_done_clr = 0; rx_done_clr = 0;
    chk("R6 cleared", {tx_done, rx_done}, 0);
  endtask

  task automatic do_tx(logic [7:0] d, bit interfere, bit with_rx);
    int bad_clk = 0, bad_sd = 0;
    @(negedge clk); tx_load = 1; tx_byte = d; rx_enable = with_rx;
    for (int n = 0; n < 96; n++) begin
      @(negedge clk);
      if (n == 0) begin tx_load = 0; rx_enable = 0; end
      if (interfere && n == 30) begin tx_load = 1; tx_byte = ~d; end
      if (interfere && n == 31) tx_load = 0;
      if (sclk_out !== exp_sclk(n)) bad_clk++;
      if (sd_out !== d[n/12] || sd_oe !== 1'b1) bad_sd++;
    end
    chk("R2 tx clock shape", bad_clk, 0);
    if (interfere) chk("R8 load while busy ignored", bad_sd, 0);
    else if (with_rx) chk("R9 tx wins over rx", bad_sd, 0);
    else chk("R3 tx bits", bad_sd, 0);
    @(negedge clk);
    chk("R5 tx_done set", tx_done, 1);
    chk("R10 idle pin", {sd_oe, sd_out, sclk_out}, 3'b011);
    if (with_rx) chk("R9 no rx flag", rx_done, 0);
    repeat (5) @(negedge clk);
    chk("R6 tx_done held", tx_done, 1);
    clear_flags();
  endtask

  task automatic do_rx(logic [7:0] d, bit clear_after);
    int bad_clk = 0, bad_oe = 0;
    @(negedge clk); rx_enable = 1;
    for (int n = 0; n < 96; n++) begin
      @(negedge clk);
      if (n == 0) rx_enable = 0;
      if (n % 12 == 0) sd_in = d[n/12];
      if (n % 12 == 10) sd_in = 1'($urandom);
      if (sclk_out !== exp_sclk(n)) bad_clk++;
      if (sd_oe !== 1'b0 || sd_out !== 1'b1) bad_oe++;
    end
    chk("R2 rx clock shape", bad_clk, 0);
    chk("R10 rx pin released", bad_oe, 0);
    @(negedge clk);
    chk("R5 rx_done set", rx_done, 1);
    chk("R4 rx byte", rx_byte, d);
    if (clear_after) clear_flags();
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {sclk_out, sd_oe, sd_out}, 3'b101);
    chk("R1 reset flags", {tx_done, rx_done}, 0);
    chk("R1 reset rx_byte", rx_byte, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2 idle high", sclk_out, 1);

    do_tx(8'h00, 0, 0);
    do_tx(8'hFF, 0, 0);
    do_tx(8'h01, 0, 0);
    do_tx(8'h80, 0, 0);
    do_tx(8'hA5, 1, 0);
    do_tx(8'h3C, 0, 1);
    for (int i = 0; i < 6; i++) do_tx(8'($urandom), 0, 0);

    do_rx(8'h55, 1);
    do_rx(8'h81, 1);
    for (int i = 0; i < 6; i++) do_rx(8'($urandom), 1);

    do_rx(8'hC3, 0);
    begin
      int moved = 0;
      rx_enable = 1;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1) moved++;
      end
      rx_enable = 0;
      chk("R7 rx blocked by flag", moved, 0);
      chk("R6 rx_done held", rx_done, 1);
      chk("R7 rx_byte kept", rx_byte, 8'hC3);
    end
    clear_flags();
    do_rx(8'h6E, 1);

    seed = seed + 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule